// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer and Chip-Select Decoder

This block sits between an 8-bit controller whose low address byte shares pins with the data bus and the external RAM, a serial interface and a set of expansion slots. While the address strobe is high the shared pins carry the low address byte, and the block follows them. From the strobe's falling edge on it holds that byte. It joins the byte with the dedicated upper address lines to form the full address.

The held address drives a decoder that produces active-low chip selects. The address strobe is never an enable on the decoder. Instead, a bus cycle is treated as open from the strobe's falling edge until the falling edge of the data strobe, and the selects stay valid for that whole window.

The low page is decoded on purpose with gaps. 0x00, 0x01 and 0x04 to 0x09 select nothing. Four two-byte pairs in that page each drive their own expansion enable. RAM covers everything from 0x10 upward, except a two-byte serial-interface window whose base is a parameter. The block samples the bus strobes on its own clock.

Top module: `mux_bus_cs_decoder`

## Requirements
- R1: On each clock edge where `as_i` is high, the block loads `bus_ad_i` and `addr_hi_i` into the address register. On every edge where `as_i` is low, the register keeps its value, so changes on the bus during the data phase do not affect which select is active.
- R2: No select is asserted in the cycle that follows a clock edge at which `as_i` was sampled high.
- R3: A select becomes valid in the cycle after the clock edge that sees `as_i` fall. It stays asserted until the edge that first sees `ds_i` low after being high, and in the following cycle all selects are high.
- R4: The full addresses 0x00, 0x01 and 0x04 through 0x09 assert no select, and no address below 0x10 asserts `ram_cs_n_o`.
- R5: Any address from 0x10 to the top of the address space asserts `ram_cs_n_o`, except the two addresses SER_BASE and SER_BASE+1.
- R6: Expansion enables are mapped as follows. Addresses 0x02/0x03 drive `exp_cs_n_o[0]`, 0x0A/0x0B drive bit 1, 0x0C/0x0D drive bit 2 and 0x0E/0x0F drive bit 3.
- R7: `ser_cs_n_o` is low only while the cycle is open, the held address is SER_BASE or SER_BASE+1, and `ds_i` is high.
- R8: At most one of the six select outputs is low at any time.
- R9: While `rst_n` is low, every select is high, including a reset that arrives in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| as_i | input | 1 | Address strobe, high while the shared pins carry the low address |
| ds_i | input | 1 | Data strobe, high during the data transfer |
| bus_ad_i | input | 8 | Shared low-address / data pins |
| addr_hi_i | input | ADDR_W-8 | Dedicated upper address lines |
| ram_cs_n_o | output | 1 | RAM select, active low |
| ser_cs_n_o | output | 1 | Serial-interface select, active low, qualified by the data strobe |
| exp_cs_n_o | output | 4 | Expansion-slot enables, active low, one per address pair |

## Verification
On every clock the assertions check the following. At most one select is low. Selects are idle after a sampled address strobe and after a data-strobe fall. The held low byte does not move while the address strobe is low. The serial select never appears without the data strobe. RAM is never chosen in the low page. What the scenarios alone can show is the address map itself: which output each address reaches, including the low-page holes, the pair boundaries and the edges of the serial window. They also show that a mid-cycle bus change and a mid-cycle reset leave the outputs where the requirements place them. An exhaustive sweep over every address compares each cycle against an independently computed map.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int unsigned NUM_EXP    = 4;
  localparam int unsigned LOW_PAGE   = 16;

  // Base of expansion pair idx: 0x02, then 0x0A, 0x0C, 0x0E.
  function automatic logic [7:0] exp_base(input int unsigned idx);
    if (idx == 0) return 8'h02;
    return 8'(8 + 2 * idx);
  endfunction
endpackage

// File: rtl/mbd_rst_sync.sv
module mbd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_n;

  always_comb sync_n = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_n;
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch #(
  parameter int unsigned ADDR_W = 13,
  localparam int unsigned HI_W = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [7:0]        bus_ad,
  input  logic [HI_W-1:0]   addr_hi,
  output logic [7:0]        lo_q,
  output logic [HI_W-1:0]   hi_q
);
  logic [7:0]      lo_n;
  logic [HI_W-1:0] hi_n;

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    if (ld_en) begin
      lo_n = bus_ad;
      hi_n = addr_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end
endmodule

// File: rtl/mbd_cycle_track.sv
module mbd_cycle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic as_i,
  input  logic ds_i,
  output logic cyc_q
);
  logic as_q, ds_q;
  logic cyc_n;
  logic as_fall, ds_fall;

  assign as_fall = as_q & ~as_i;
  assign ds_fall = ds_q & ~ds_i;

  always_comb begin
    cyc_n = cyc_q;
    if (as_i)         cyc_n = 1'b0;
    else if (ds_fall) cyc_n = 1'b0;
    else if (as_fall) cyc_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q  <= 1'b0;
      ds_q  <= 1'b0;
      cyc_q <= 1'b0;
    end else begin
      as_q  <= as_i;
      ds_q  <= ds_i;
      cyc_q <= cyc_n;
    end
  end
endmodule

// File: rtl/mbd_decode.sv
module mbd_decode
  import mbd_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 13,
  parameter logic [ADDR_W-1:0] SER_BASE = 'h0040
) (
  input  logic [ADDR_W-1:0]  full_addr,
  input  logic               cyc,
  input  logic               ds,
  output logic               ram_cs_n,
  output logic               ser_cs_n,
  output logic [NUM_EXP-1:0] exp_cs_n
);
  logic               ser_hit;
  logic               ram_hit;
  logic [NUM_EXP-1:0] exp_hit;

  assign ser_hit = (full_addr[ADDR_W-1:1] == SER_BASE[ADDR_W-1:1]);
  assign ram_hit = (full_addr >= ADDR_W'(LOW_PAGE)) && !ser_hit;

  for (genvar g = 0; g < NUM_EXP; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_BASE = ADDR_W'(exp_base(g));
    assign exp_hit[g] = (full_addr[ADDR_W-1:1] == SLOT_BASE[ADDR_W-1:1]);
    assign exp_cs_n[g] = ~(cyc & exp_hit[g]);
  end

  assign ram_cs_n = ~(cyc & ram_hit);
  assign ser_cs_n = ~(cyc & ds & ser_hit);
endmodule

// File: rtl/mux_bus_cs_decoder.sv
module mux_bus_cs_decoder
  import mbd_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 13,
  parameter logic [ADDR_W-1:0] SER_BASE = 'h0040,
  localparam int unsigned      HI_W     = ADDR_W - 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               as_i,
  input  logic               ds_i,
  input  logic [7:0]         bus_ad_i,
  input  logic [HI_W-1:0]    addr_hi_i,
  output logic               ram_cs_n_o,
  output logic               ser_cs_n_o,
  output logic [NUM_EXP-1:0] exp_cs_n_o
);
  logic              rst_core_n;
  logic [7:0]        lat_lo;
  logic [HI_W-1:0]   lat_hi;
  logic [ADDR_W-1:0] full_addr;
  logic              cyc;

  mbd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  mbd_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ld_en   (as_i),
    .bus_ad  (bus_ad_i),
    .addr_hi (addr_hi_i),
    .lo_q    (lat_lo),
    .hi_q    (lat_hi)
  );

  mbd_cycle_track u_cyc (
    .clk   (clk),
    .rst_n (rst_core_n),
    .as_i  (as_i),
    .ds_i  (ds_i),
    .cyc_q (cyc)
  );

  assign full_addr = {lat_hi, lat_lo};

  mbd_decode #(.ADDR_W(ADDR_W), .SER_BASE(SER_BASE)) u_dec (
    .full_addr (full_addr),
    .cyc       (cyc),
    .ds        (ds_i),
    .ram_cs_n  (ram_cs_n_o),
    .ser_cs_n  (ser_cs_n_o),
    .exp_cs_n  (exp_cs_n_o)
  );
endmodule

// File: rtl/mux_bus_cs_decoder_chk.sv
module mux_bus_cs_decoder_chk #(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned NUM_EXP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               as_i,
  input logic               ds_i,
  input logic               ram_cs_n_o,
  input logic               ser_cs_n_o,
  input logic [NUM_EXP-1:0] exp_cs_n_o,
  input logic [7:0]         lat_lo,
  input logic [ADDR_W-1:0]  full_addr
);
  logic [NUM_EXP+1:0] sel_act;
  logic               all_idle;

  assign sel_act  = ~{ram_cs_n_o, ser_cs_n_o, exp_cs_n_o};
  assign all_idle = (sel_act == '0);

  p_one_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_act));

  p_reset_idle_r9: assert property (@(posedge clk)
    !rst_n |-> all_idle);

  p_as_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    as_i |=> all_idle);

  p_ds_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ds_i) && !ds_i) |=> all_idle);

  p_ram_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n_o && !as_i && !($past(ds_i) && !ds_i)) |=> !ram_cs_n_o);

  p_lo_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !as_i |=> $stable(lat_lo));

  p_ser_needs_ds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_cs_n_o |-> ds_i);

  p_no_ram_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_addr < ADDR_W'(16)) |-> ram_cs_n_o);
endmodule

bind mux_bus_cs_decoder mux_bus_cs_decoder_chk #(
  .ADDR_W  (ADDR_W),
  .NUM_EXP (mbd_pkg::NUM_EXP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .as_i       (as_i),
  .ds_i       (ds_i),
  .ram_cs_n_o (ram_cs_n_o),
  .ser_cs_n_o (ser_cs_n_o),
  .exp_cs_n_o (exp_cs_n_o),
  .lat_lo     (lat_lo),
  .full_addr  (full_addr)
);

// File: tb/mux_bus_cs_decoder_test.sv
module mux_bus_cs_decoder_test;
  localparam int unsigned ADDR_W   = 13;
  localparam int unsigned HI_W     = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] SER_BASE = 'h0040;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            as_i, ds_i;
  logic [7:0]      bus_ad_i;
  logic [HI_W-1:0] addr_hi_i;
  logic            ram_cs_n_o, ser_cs_n_o;
  logic [3:0]      exp_cs_n_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_cs_decoder #(.ADDR_W(ADDR_W), .SER_BASE(SER_BASE)) uut (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .ds_i(ds_i),
    .bus_ad_i(bus_ad_i), .addr_hi_i(addr_hi_i),
    .ram_cs_n_o(ram_cs_n_o), .ser_cs_n_o(ser_cs_n_o), .exp_cs_n_o(exp_cs_n_o)
  );

  // Active-high view: {ram, ser, exp3..exp0}
  function automatic logic [5:0] got_sel();
    return ~{ram_cs_n_o, ser_cs_n_o, exp_cs_n_o};
  endfunction

  // Expected map from the requirements (R4, R5, R6, R7).
  function automatic logic [5:0] want_sel(input int a, input bit ds_on);
    logic [5:0] w = '0;
    if (a < 16) begin
      if (a == 2 || a == 3)        w[0] = 1'b1;
      else if (a == 10 || a == 11) w[1] = 1'b1;
      else if (a == 12 || a == 13) w[2] = 1'b1;
      else if (a == 14 || a == 15) w[3] = 1'b1;
    end else if (a == int'(SER_BASE) || a == int'(SER_BASE) + 1) begin
      w[4] = ds_on;
    end else begin
      w[5] = 1'b1;
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  // Address phase: drive strobe high with address, then lower it.
  // Returns at the negedge just after the strobe is lowered.
  task automatic addr_phase(input int a, input string req);
    bus_ad_i  = a[7:0];
    addr_hi_i = a[ADDR_W-1:8];
    as_i      = 1'b1;
    @(negedge clk);
    check(req, got_sel(), 6'b0);
    as_i     = 1'b0;
    bus_ad_i = 8'h5A;
  endtask

  task automatic full_cycle(input int a, input string req);
    addr_phase(a, req);
    @(negedge clk);
    check(req, got_sel(), want_sel(a, 1'b0));
    ds_i = 1'b1;
    @(negedge clk);
    check(req, got_sel(), want_sel(a, 1'b1));
    ds_i = 1'b0;
    @(negedge clk);
    check(req, got_sel(), 6'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; as_i = 1'b0; ds_i = 1'b0; bus_ad_i = '0; addr_hi_i = '0;
    repeat (3) @(negedge clk);
    check("R9", got_sel(), 6'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", got_sel(), 6'b0);
  endtask

  task automatic t_low_page();
    for (int a = 0; a < 16; a++) full_cycle(a, (a inside {0,1,[4:9]}) ? "R4" : "R6");
  endtask

  task automatic t_ram_edges();
    full_cycle(16, "R5");
    full_cycle(int'(SER_BASE) - 1, "R5");
    full_cycle(int'(SER_BASE) + 2, "R5");
    full_cycle((1 << ADDR_W) - 1, "R5");
  endtask

  task automatic t_serial();
    full_cycle(int'(SER_BASE), "R7");
    full_cycle(int'(SER_BASE) + 1, "R7");
  endtask

  // R1: bus and upper lines change during the data phase; select unchanged.
  task automatic t_hold();
    addr_phase(12'h123, "R2");
    @(negedge clk);
    bus_ad_i = 8'h0C; addr_hi_i = '0;
    @(negedge clk);
    check("R1", got_sel(), want_sel(12'h123, 1'b0));
    ds_i = 1'b1; bus_ad_i = 8'h02;
    @(negedge clk);
    check("R1", got_sel(), want_sel(12'h123, 1'b1));
    ds_i = 1'b0;
    @(negedge clk);
    check("R3", got_sel(), 6'b0);
  endtask

  // R3: long data phase keeps select; release follows the data strobe fall.
  task automatic t_long_cycle();
    addr_phase(12'h0E, "R2");
    repeat (4) begin
      @(negedge clk);
      check("R3", got_sel(), 6'b001000);
    end
    ds_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R3", got_sel(), 6'b001000);
    end
    ds_i = 1'b0;
    @(negedge clk);
    check("R3", got_sel(), 6'b0);
    repeat (2) begin
      @(negedge clk);
      check("R2", got_sel(), 6'b0);
    end
  endtask

  // R9: reset in the middle of an open cycle.
  task automatic t_mid_reset();
    addr_phase(12'h200, "R2");
    @(negedge clk);
    check("R5", got_sel(), 6'b100000);
    rst_n = 1'b0;
    #1;
    check("R9", got_sel(), 6'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", got_sel(), 6'b0);
  endtask

  // R8: sweep every address; each phase compared to the map and one-hot.
  task automatic t_sweep();
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      full_cycle(a, "R8");
      checks++;
      if ($countones(got_sel()) > 1) begin
        errors++;
        $display("FAIL R8 got=%b expected=at most one active", got_sel());
      end
    end
  endtask

  initial begin
    t_reset();
    t_low_page();
    t_ram_edges();
    t_serial();
    t_hold();
    t_long_cycle();
    t_mid_reset();
    t_sweep();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule